// File: doc/BRIEF.md
# I2C Master Status and Interrupt Register Unit

This unit holds the host-visible status, interrupt and mode registers of an I2C master controller and drives its single interrupt line. The transfer sequencer and the data buffer report events to it as one-cycle pulses: a transfer finished with a byte count, a halt finished, an error, a successful bus start, and the buffer's first-byte and full flags. The unit merges these with host writes. Some registers clear selected bits when written with ones, and the mode register holds a global interrupt enable.

The host sees an 18-byte window that it accesses one byte per cycle. Reads are combinational from the stored registers. The extended-status byte is computed live from the bus-busy input. The unit also stores the master and slave address bytes, the control byte, the clock divider, the interrupt mask and a small direct-control byte. A soft reset written by the host returns the resettable state to its reset values and leaves the address bytes untouched. The unit emits a one-cycle soft-reset pulse and a one-cycle buffer-flush pulse for its neighbours.

Top module: `i2cm_stat_irq`

## Requirements
- R1: Offsets decoded inside the 18-byte window: 4/5 master address low/high, 6 control, 7 mode, 8 status, 9 extended status, 10/11 slave address low/high, 12 clock divider, 13 interrupt mask, 14 byte count, 15 extended control, 16 direct control. Offsets 0–3 and 17 inside the window, and every offset from 18 upward, read 0x00, and writes to them change no register.
- R2: A host write to status (offset 8) clears only the bits that are set in both the written byte and 0x0A. If bit 1 is written as 1 while mode bit 2 is set, the interrupt output drops on the next cycle.
- R3: A mode write (offset 7) stores the byte ANDed with 0x3D. When the written byte has bit 6 set, flush_pulse is high for exactly the following cycle and status bits 4 and 5 are cleared.
- R4: Extended status (offset 9) reads 0x50 while bus_busy is 1 and 0x40 while it is 0. Writes to it have no effect.
- R5: A byte-count write (offset 14) stores the byte ANDed with 0x77. An ev_done pulse loads ev_count into the byte count and takes priority over a host write in the same cycle.
- R6: An ev_done pulse with nonzero ev_count sets status bit 1 and raises irq when mode bit 2 and mask bit 0 are both set. An ev_halt pulse does the same under mode bit 2 and mask bit 3. ev_done with a zero count raises nothing. irq stays high until cleared by R2, by soft reset or by reset.
- R7: Writing offset 15 with bit 0 set resets control, mode, status, clock divider, mask, byte count, extended control, direct control and irq, exactly as rst does. It keeps the four address bytes, and soft_rst_pulse is high for exactly the following cycle. Extended control always reads 0x00.
- R8: After rst, every decoded offset reads 0x00 except offset 9 (0x40 while the bus is free) and offset 16 (0x0F). The address bytes keep the values written before rst.
- R9: A control write stores the byte with bit 0 cleared. The address bytes, clock divider and mask store the whole byte. Direct control stores the low four bits.
- R10: In status, ev_err sets bit 2 and ev_start_ok clears it, ev_buf_full sets bit 4 and ev_buf_start sets bit 5. An event that sets a bit takes priority over a host clear or a flush in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host byte write strobe |
| host_addr | input | ADDR_W | Host byte offset |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Read byte for host_addr (combinational) |
| bus_busy | input | 1 | I2C bus currently owned |
| ev_done | input | 1 | Transfer finished pulse |
| ev_count | input | CNT_W | Bytes completed with ev_done |
| ev_halt | input | 1 | Halt finished pulse |
| ev_err | input | 1 | Transfer error pulse |
| ev_start_ok | input | 1 | Successful bus start pulse |
| ev_buf_start | input | 1 | Buffer holds its first byte |
| ev_buf_full | input | 1 | Buffer became full |
| irq | output | 1 | Interrupt request level |
| flush_pulse | output | 1 | One-cycle buffer flush request |
| soft_rst_pulse | output | 1 | One-cycle soft-reset indication |

## Verification
The bench builds the unit with its defaults: a 5-bit offset, an 18-byte window and a 3-bit byte count. A 5-bit offset covers all 32 offsets, so one read sweep exercises both the window's holes and the offsets beyond its end. Every one of the 256 byte values is written to the mode and byte-count registers and checked against its mask. The interrupt check sweeps every combination of global enable, all 16 low mask values and both event sources, and then clears each raised interrupt through the status register.

// File: rtl/sir_pkg.sv
package sir_pkg;
    localparam int unsigned REG_W = 8;

    localparam int unsigned OFF_MADR_LO = 4;
    localparam int unsigned OFF_MADR_HI = 5;
    localparam int unsigned OFF_CTRL    = 6;
    localparam int unsigned OFF_MODE    = 7;
    localparam int unsigned OFF_STAT    = 8;
    localparam int unsigned OFF_XSTAT   = 9;
    localparam int unsigned OFF_SADR_LO = 10;
    localparam int unsigned OFF_SADR_HI = 11;
    localparam int unsigned OFF_CLKDIV  = 12;
    localparam int unsigned OFF_IMASK   = 13;
    localparam int unsigned OFF_COUNT   = 14;
    localparam int unsigned OFF_XCTRL   = 15;
    localparam int unsigned OFF_DCTRL   = 16;

    localparam logic [REG_W-1:0] STAT_W1C   = 8'h0A;
    localparam logic [REG_W-1:0] MODE_KEEP  = 8'h3D;
    localparam logic [REG_W-1:0] COUNT_KEEP = 8'h77;
    localparam logic [REG_W-1:0] XCTRL_W1C  = 8'hF0;
    localparam logic [REG_W-1:0] XSTAT_FREE = 8'h40;
    localparam logic [REG_W-1:0] XSTAT_BUSY = 8'h50;
    localparam logic [REG_W-1:0] DCTRL_INIT = 8'h0F;

    localparam int unsigned MODE_GEN_BIT   = 2;
    localparam int unsigned MODE_FLUSH_BIT = 6;
    localparam int unsigned MASK_DONE_BIT  = 0;
    localparam int unsigned MASK_HALT_BIT  = 3;

    typedef struct packed {
        logic [1:0] zero_hi;
        logic       buf_start;
        logic       buf_full;
        logic       rsv3;
        logic       err;
        logic       irqa;
        logic       rsv0;
    } stat_t;

    function automatic logic [REG_W-1:0] xstat_value(input logic busy);
        return busy ? XSTAT_BUSY : XSTAT_FREE;
    endfunction
endpackage

// File: rtl/sir_decode.sv
module sir_decode #(
    parameter int unsigned ADDR_W    = 5,
    parameter int unsigned WIN_BYTES = 18
) (
    input  logic [ADDR_W-1:0]    host_addr,
    output logic [WIN_BYTES-1:0] sel
);
    for (genvar i = 0; i < WIN_BYTES; i++) begin : g_sel
        assign sel[i] = (host_addr == ADDR_W'(i));
    end

    always_comb begin
        assert ($countones(sel) <= 1)
            else $error("decode selects more than one byte");
    end
endmodule

// File: rtl/sir_irq.sv
module sir_irq (
    input  logic       clk,
    input  logic       rst,
    input  logic       soft_rst,
    input  logic       gen_en,
    input  logic       mask_done,
    input  logic       mask_halt,
    input  logic       done_nz,
    input  logic       halt,
    input  logic       clr_req,
    output logic       irqa_set,
    output logic       irq
);
    logic irq_q;

    assign irqa_set = gen_en && ((done_nz && mask_done) || (halt && mask_halt));

    always_ff @(posedge clk) begin
        if (rst || soft_rst)         irq_q <= 1'b0;
        else if (irqa_set)           irq_q <= 1'b1;
        else if (clr_req && gen_en)  irq_q <= 1'b0;
    end

    assign irq = irq_q;

    // R6
    irq_raise_chk: assert property (@(posedge clk) disable iff (rst)
        (!soft_rst && gen_en && done_nz && mask_done) |=> irq_q);

    // R2
    irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_req && gen_en && !done_nz && !halt) |=> !irq_q);

    // R6
    irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_q && !soft_rst && !clr_req) |=> irq_q);
endmodule

// File: rtl/i2cm_stat_irq.sv
module i2cm_stat_irq
    import sir_pkg::*;
#(
    parameter int unsigned ADDR_W    = 5,
    parameter int unsigned WIN_BYTES = 18,
    parameter int unsigned CNT_W     = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 host_wr,
    input  logic [ADDR_W-1:0]    host_addr,
    input  logic [REG_W-1:0]     host_wdata,
    output logic [REG_W-1:0]     host_rdata,
    input  logic                 bus_busy,
    input  logic                 ev_done,
    input  logic [CNT_W-1:0]     ev_count,
    input  logic                 ev_halt,
    input  logic                 ev_err,
    input  logic                 ev_start_ok,
    input  logic                 ev_buf_start,
    input  logic                 ev_buf_full,
    output logic                 irq,
    output logic                 flush_pulse,
    output logic                 soft_rst_pulse
);
    localparam int unsigned PAD_W = REG_W - CNT_W;

    logic [WIN_BYTES-1:0] sel;
    logic [REG_W-1:0] madr_lo_q, madr_hi_q, sadr_lo_q, sadr_hi_q;
    logic [REG_W-1:0] ctrl_q, mode_q, clkdiv_q, imask_q, count_q, xctrl_q, dctrl_q;
    stat_t            stat_q, stat_n;
    logic             flush_q, srst_q;
    logic             wr_stat, wr_mode, flush_req, srst_req, irqa_set, done_nz;

    sir_decode #(.ADDR_W(ADDR_W), .WIN_BYTES(WIN_BYTES)) u_dec (
        .host_addr (host_addr),
        .sel       (sel)
    );

    assign wr_stat   = host_wr && sel[OFF_STAT];
    assign wr_mode   = host_wr && sel[OFF_MODE];
    assign flush_req = wr_mode && host_wdata[MODE_FLUSH_BIT];
    assign srst_req  = host_wr && sel[OFF_XCTRL] && host_wdata[0];
    assign done_nz   = ev_done && (ev_count != '0);

    sir_irq u_irq (
        .clk       (clk),
        .rst       (rst),
        .soft_rst  (srst_req),
        .gen_en    (mode_q[MODE_GEN_BIT]),
        .mask_done (imask_q[MASK_DONE_BIT]),
        .mask_halt (imask_q[MASK_HALT_BIT]),
        .done_nz   (done_nz),
        .halt      (ev_halt),
        .clr_req   (wr_stat && host_wdata[1]),
        .irqa_set  (irqa_set),
        .irq       (irq)
    );

    always_comb begin
        stat_n = stat_q;
        if (wr_stat)       stat_n = stat_n & ~stat_t'(host_wdata & STAT_W1C);
        if (flush_req) begin
            stat_n.buf_start = 1'b0;
            stat_n.buf_full  = 1'b0;
        end
        if (ev_start_ok)   stat_n.err       = 1'b0;
        if (ev_err)        stat_n.err       = 1'b1;
        if (ev_buf_full)   stat_n.buf_full  = 1'b1;
        if (ev_buf_start)  stat_n.buf_start = 1'b1;
        if (irqa_set)      stat_n.irqa      = 1'b1;
    end

    // Address bytes survive both reset kinds.
    always_ff @(posedge clk) begin
        if (host_wr && sel[OFF_MADR_LO]) madr_lo_q <= host_wdata;
        if (host_wr && sel[OFF_MADR_HI]) madr_hi_q <= host_wdata;
        if (host_wr && sel[OFF_SADR_LO]) sadr_lo_q <= host_wdata;
        if (host_wr && sel[OFF_SADR_HI]) sadr_hi_q <= host_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || srst_req) begin
            ctrl_q   <= '0;
            mode_q   <= '0;
            stat_q   <= '0;
            clkdiv_q <= '0;
            imask_q  <= '0;
            count_q  <= '0;
            xctrl_q  <= '0;
            dctrl_q  <= DCTRL_INIT;
        end else begin
            stat_q <= stat_n;
            if (host_wr && sel[OFF_CTRL])   ctrl_q   <= host_wdata & 8'hFE;
            if (wr_mode)                    mode_q   <= host_wdata & MODE_KEEP;
            if (host_wr && sel[OFF_CLKDIV]) clkdiv_q <= host_wdata;
            if (host_wr && sel[OFF_IMASK])  imask_q  <= host_wdata;
            if (host_wr && sel[OFF_XCTRL])  xctrl_q  <= xctrl_q & ~(host_wdata & XCTRL_W1C);
            if (host_wr && sel[OFF_DCTRL])  dctrl_q  <= {4'h0, host_wdata[3:0]};
            if (ev_done)                    count_q  <= {{PAD_W{1'b0}}, ev_count};
            else if (host_wr && sel[OFF_COUNT]) count_q <= host_wdata & COUNT_KEEP;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flush_q <= 1'b0;
            srst_q  <= 1'b0;
        end else begin
            flush_q <= flush_req;
            srst_q  <= srst_req;
        end
    end

    assign flush_pulse    = flush_q;
    assign soft_rst_pulse = srst_q;

    always_comb begin
        host_rdata = '0;
        if (sel[OFF_MADR_LO]) host_rdata = madr_lo_q;
        if (sel[OFF_MADR_HI]) host_rdata = madr_hi_q;
        if (sel[OFF_CTRL])    host_rdata = ctrl_q;
        if (sel[OFF_MODE])    host_rdata = mode_q;
        if (sel[OFF_STAT])    host_rdata = stat_q;
        if (sel[OFF_XSTAT])   host_rdata = xstat_value(bus_busy);
        if (sel[OFF_SADR_LO]) host_rdata = sadr_lo_q;
        if (sel[OFF_SADR_HI]) host_rdata = sadr_hi_q;
        if (sel[OFF_CLKDIV])  host_rdata = clkdiv_q;
        if (sel[OFF_IMASK])   host_rdata = imask_q;
        if (sel[OFF_COUNT])   host_rdata = count_q;
        if (sel[OFF_XCTRL])   host_rdata = xctrl_q;
        if (sel[OFF_DCTRL])   host_rdata = dctrl_q;
    end

    // R5
    count_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (host_wr && sel[OFF_COUNT] && !ev_done && !srst_req) |=>
        (count_q == ($past(host_wdata) & COUNT_KEEP)));

    // R7
    soft_rst_chk: assert property (@(posedge clk) disable iff (rst)
        soft_rst_pulse |-> (mode_q == '0 && imask_q == '0 && count_q == '0 && !irq));

    // R3
    flush_chk: assert property (@(posedge clk) disable iff (rst)
        (flush_pulse && !$past(ev_buf_full) && !$past(ev_buf_start)) |->
        (!stat_q.buf_full && !stat_q.buf_start));

    // R3
    flush_once_chk: assert property (@(posedge clk) disable iff (rst)
        (flush_pulse && !$past(flush_req, 2)) |=> !flush_pulse || $past(flush_req));
endmodule

// File: tb/i2cm_stat_irq_tb_top.sv
module i2cm_stat_irq_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_wr = 1'b0;
    logic [4:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       bus_busy = 1'b0;
    logic       ev_done = 1'b0;
    logic [2:0] ev_count = '0;
    logic       ev_halt = 1'b0, ev_err = 1'b0, ev_start_ok = 1'b0;
    logic       ev_buf_start = 1'b0, ev_buf_full = 1'b0;
    logic       irq, flush_pulse, soft_rst_pulse;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    i2cm_stat_irq dut_i (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .bus_busy(bus_busy),
        .ev_done(ev_done), .ev_count(ev_count), .ev_halt(ev_halt), .ev_err(ev_err),
        .ev_start_ok(ev_start_ok), .ev_buf_start(ev_buf_start), .ev_buf_full(ev_buf_full),
        .irq(irq), .flush_pulse(flush_pulse), .soft_rst_pulse(soft_rst_pulse)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = 5'(a); host_wdata = 8'(d);
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        host_addr = 5'(a);
        #1;
        d = int'(host_rdata);
    endtask

    task automatic pulse_done(input int cnt);
        @(negedge clk);
        ev_done = 1'b1; ev_count = 3'(cnt);
        @(negedge clk);
        ev_done = 1'b0;
    endtask

    task automatic pulse_halt();
        @(negedge clk); ev_halt = 1'b1;
        @(negedge clk); ev_halt = 1'b0;
    endtask

    function automatic int reset_val(input int a);
        case (a)
            4: return 8'hA4;  5: return 8'hA5;
            10: return 8'hAA; 11: return 8'hAB;
            9: return 8'h40;  16: return 8'h0F;
            default: return 0;
        endcase
    endfunction

    initial begin
        int v;
        int snap [32];
        repeat (3) @(negedge clk);
        rst = 1'b0;
        wr(4, 8'hA4); wr(5, 8'hA5); wr(10, 8'hAA); wr(11, 8'hAB);
        wr(7, 8'h04); wr(13, 8'hFF);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        // R8 and R1: full offset sweep after reset
        for (int a = 0; a < 32; a++) begin
            rd(a, v);
            check($sformatf("R8 offset %0d", a), v, reset_val(a));
        end
        check("R8 irq after reset", int'(irq), 0);

        // R9: plain storage registers
        for (int d = 0; d < 256; d += 17) begin
            wr(6, d);  rd(6, v);  check("R9 control", v, d & 8'hFE);
            wr(12, d); rd(12, v); check("R9 clkdiv", v, d);
            wr(13, d); rd(13, v); check("R9 mask", v, d);
            wr(16, d); rd(16, v); check("R9 direct", v, d & 8'h0F);
            wr(4, d);  rd(4, v);  check("R9 madr", v, d);
        end

        // R3: mode mask and flush pulse, all byte values
        for (int d = 0; d < 256; d++) begin
            wr(7, d);
            check("R3 flush pulse", int'(flush_pulse), (d >> 6) & 1);
            rd(7, v); check("R3 mode mask", v, d & 8'h3D);
            @(negedge clk);
            check("R3 flush one cycle", int'(flush_pulse), 0);
        end

        // R5: count mask, all byte values, and event load
        for (int d = 0; d < 256; d++) begin
            wr(14, d); rd(14, v); check("R5 count mask", v, d & 8'h77);
        end
        wr(7, 8'h00);
        pulse_done(5); rd(14, v); check("R5 count load", v, 5);
        @(negedge clk);
        host_wr = 1'b1; host_addr = 5'd14; host_wdata = 8'h33;
        ev_done = 1'b1; ev_count = 3'd6;
        @(negedge clk);
        host_wr = 1'b0; ev_done = 1'b0;
        rd(14, v); check("R5 event over write", v, 6);

        // R4: live extended status, writes ignored
        for (int b = 0; b < 2; b++) begin
            bus_busy = b[0];
            wr(9, 8'hFF);
            rd(9, v); check("R4 xstat", v, b ? 8'h50 : 8'h40);
        end
        bus_busy = 1'b0;

        // R6 and R2: interrupt sweep
        for (int en = 0; en < 2; en++)
            for (int m = 0; m < 16; m++)
                for (int src = 0; src < 2; src++) begin
                    int exp;
                    wr(7, 8'h04); wr(8, 8'h02);
                    wr(7, en ? 8'h04 : 8'h00); wr(13, m);
                    if (src == 0) pulse_done(3); else pulse_halt();
                    exp = (en != 0) && (src == 0 ? (m & 1) != 0 : (m & 8) != 0);
                    check("R6 irq", int'(irq), exp);
                    rd(8, v); check("R6 status irq bit", (v >> 1) & 1, exp);
                    wr(8, 8'h02);
                    check("R2 irq cleared", int'(irq), 0);
                    rd(8, v); check("R2 status bit cleared", (v >> 1) & 1, 0);
                end
        wr(7, 8'h04); wr(13, 8'h01);
        pulse_done(0);
        check("R6 zero count no irq", int'(irq), 0);
        pulse_done(1);
        wr(7, 8'h00); wr(8, 8'h02);
        check("R2 clear without enable keeps irq", int'(irq), 1);
        rd(8, v); check("R2 status bit cleared", (v >> 1) & 1, 0);

        // R10 and R2: status sources and clear mask
        @(negedge clk); ev_err = 1'b1; ev_buf_full = 1'b1; ev_buf_start = 1'b1;
        @(negedge clk); ev_err = 1'b0; ev_buf_full = 1'b0; ev_buf_start = 1'b0;
        rd(8, v); check("R10 status set", v, 8'h34);
        wr(8, 8'hFF); rd(8, v); check("R2 clear mask only", v, 8'h34);
        @(negedge clk); ev_start_ok = 1'b1;
        @(negedge clk); ev_start_ok = 1'b0;
        rd(8, v); check("R10 start clears err", v, 8'h30);
        @(negedge clk);
        host_wr = 1'b1; host_addr = 5'd7; host_wdata = 8'h40; ev_buf_full = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; ev_buf_full = 1'b0;
        rd(8, v); check("R10 set beats flush", v, 8'h10);
        wr(7, 8'h40); rd(8, v); check("R3 flush clears flags", v, 8'h00);

        // R1: writes outside decoded offsets change nothing
        for (int a = 0; a < 32; a++) rd(a, snap[a]);
        for (int a = 0; a < 32; a++)
            if (a < 4 || a > 16) wr(a, 8'hFF);
        for (int a = 0; a < 32; a++) begin
            rd(a, v); check($sformatf("R1 unaffected %0d", a), v, snap[a]);
        end

        // R7: soft reset
        wr(4, 8'h5A); wr(11, 8'hC3); wr(13, 8'h0F); wr(7, 8'h04); wr(14, 8'h11);
        pulse_halt();
        check("R7 irq before soft reset", int'(irq), 1);
        wr(15, 8'hF1);
        check("R7 soft pulse", int'(soft_rst_pulse), 1);
        check("R7 irq cleared", int'(irq), 0);
        for (int a = 0; a < 32; a++) begin
            int exp;
            exp = (a == 4) ? 8'h5A : (a == 11) ? 8'hC3 : (a == 5) ? 8'hA5 :
                  (a == 10) ? 8'hAA : (a == 9) ? 8'h40 : (a == 16) ? 8'h0F : 0;
            rd(a, v); check($sformatf("R7 offset %0d", a), v, exp);
        end
        @(negedge clk);
        check("R7 pulse one cycle", int'(soft_rst_pulse), 0);
        wr(15, 8'hF0); check("R7 no pulse without bit0", int'(soft_rst_pulse), 0);

        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule